// File: doc/BRIEF.md
# Real-to-Absolute Prefix Mapper with Frame Key Recording

This block sits after address translation in a processor's memory path. It turns a real address into an absolute address by swapping the lowest 8 KB of real storage with an 8 KB prefix area owned by the processor. When translation is switched off, the logical address is used as the real address, and the same swap still applies.

Each accepted request that succeeded and lands inside configured memory also updates a 7-bit key held for its 4 KB frame. The update is a two-cycle read-modify-write. It sets the referenced bit when read permission was granted and the changed bit when write permission was granted.

A small host port reads and writes key entries directly. It is used to preload keys and to inspect them.

The control is a three-state machine:

- `ST_IDLE`: waits for a request. An accepted request that must update a key moves to `ST_FETCH`; any other request stays in `ST_IDLE`.
- `ST_FETCH`: reads the frame's key and always moves to `ST_STORE`.
- `ST_STORE`: writes the merged key back and returns to `ST_IDLE`.

Top module: `pfx_keymap`

## Requirements
- R1: A real address whose bits above bit 12 are all zero (below 0x2000) maps to the real address plus the prefix area base.
- R2: A real address inside the prefix area (base up to base+0x2000, exclusive) maps to the real address minus the base.
- R3: Every other real address comes out unchanged; this includes addresses just past the low block and just below the prefix area.
- R4: `prefix_blk` is an 8 KB block number, so the prefix area base is `prefix_blk`×0x2000. A new value takes effect on the next accepted request.
- R5: With `dat_on` low, `log_addr` is the real address, `xlat_addr` and `xlat_ok` are ignored, the request counts as successful, and R1 to R3 still apply.
- R6: A request is accepted when `req_valid` is high while `busy` is low. One cycle after acceptance, `resp_valid` pulses high for one cycle with `abs_addr` holding the result. `resp_valid` is low at all other times.
- R7: A key update starts only when the request succeeded and the absolute address is below both `mem_top` and the key array capacity (frames×4096). Otherwise no key changes and `busy` stays low.
- R8: The key entry index is absolute address bits [17:12] for the default 64 frames. Key layout: bits 6:3 access control, bit 2 fetch-protect, bit 1 referenced, bit 0 changed. The update ORs in referenced when `perm_rd` is high and changed when `perm_wr` is high, leaving every other bit as it was.
- R9: `busy` is high for exactly two cycles, starting in the cycle of `resp_valid`, for an updating request. A `req_valid` seen while `busy` is high is ignored: no response and no key change.
- R10: A host write (`kp_en`, `kp_we`) stores `kp_wdata` into entry `kp_idx`. A host read (`kp_en` with `kp_we` low) presents that entry on `kp_rdata` one cycle later.
- R11: Reset clears `busy`, `resp_valid`, `abs_addr`, `kp_rdata` and all key entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| dat_on | input | 1 | Dynamic translation enabled |
| xlat_addr | input | AW | Real address from the translation walk |
| log_addr | input | AW | Logical address, used when translation is off |
| xlat_ok | input | 1 | Translation succeeded |
| perm_rd | input | 1 | Read permission granted |
| perm_wr | input | 1 | Write permission granted |
| prefix_blk | input | AW-13 | Prefix area as 8 KB block number |
| mem_top | input | AW | Configured memory size in bytes |
| busy | output | 1 | Key read-modify-write in progress |
| resp_valid | output | 1 | Absolute address valid |
| abs_addr | output | AW | Absolute address |
| kp_en | input | 1 | Host key port enable |
| kp_we | input | 1 | Host key port write |
| kp_idx | input | log2(KEY_FRAMES) | Host key entry index |
| kp_wdata | input | 7 | Host key write data |
| kp_rdata | output | 7 | Host key read data |

## Verification
The mapping is driven with addresses at both edges of the low block and of the prefix area, just outside each, and under several prefix values including zero. This separates the swap, the reverse swap and pass-through, and shows whether the wrong rule wins. Requests that fail, that land above `mem_top`, or that carry no permission bits show whether the key update is correctly gated and correctly merged. Keys are preloaded with distinct patterns so that any clobbered bit is visible. A request placed while `busy` is high, together with a request issued with translation off and a bogus translated address, shows that ignored inputs truly have no effect.

// File: rtl/pkm_pkg.sv
package pkm_pkg;
    localparam int FRAME_SHIFT = 12;
    localparam int BLOCK_SHIFT = 13;

    typedef struct packed {
        logic [3:0] acc;
        logic       fetch_prot;
        logic       refd;
        logic       chgd;
    } key_t;

    localparam int KEY_W = $bits(key_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE
    } rmw_state_e;
endpackage

// File: rtl/pkm_remap.sv
module pkm_remap
    import pkm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]          real_addr,
    input  logic [AW-BLOCK_SHIFT-1:0] pfx_blk,
    output logic [AW-1:0]          abs_addr
);
    localparam int HI_W = AW - BLOCK_SHIFT;

    logic [HI_W-1:0] real_hi;
    assign real_hi = real_addr[AW-1:BLOCK_SHIFT];

    always_comb begin
        if (real_hi == '0) begin
            abs_addr = {pfx_blk, real_addr[BLOCK_SHIFT-1:0]};
        end else if (real_hi == pfx_blk) begin
            abs_addr = {{HI_W{1'b0}}, real_addr[BLOCK_SHIFT-1:0]};
        end else begin
            abs_addr = real_addr;
        end
    end
endmodule

// File: rtl/pkm_keyram.sv
module pkm_keyram
    import pkm_pkg::*;
#(
    parameter int KEY_FRAMES = 64,
    parameter int IDX_W      = $clog2(KEY_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rmw_rd,
    input  logic             rmw_wr,
    input  logic [IDX_W-1:0] rmw_idx,
    input  key_t             rmw_wdata,
    output key_t             rmw_q,
    input  logic             host_en,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  key_t             host_wdata,
    output key_t             host_q
);
    key_t ent [KEY_FRAMES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < KEY_FRAMES; i++) begin
                ent[i] <= '0;
            end
            rmw_q  <= '0;
            host_q <= '0;
        end else begin
            if (rmw_rd) begin
                rmw_q <= ent[rmw_idx];
            end
            if (host_en && !host_we) begin
                host_q <= ent[host_idx];
            end
            if (rmw_wr) begin
                ent[rmw_idx] <= rmw_wdata;
            end else if (host_en && host_we) begin
                ent[host_idx] <= host_wdata;
            end
        end
    end
endmodule

// File: rtl/pkm_ctrl.sv
module pkm_ctrl
    import pkm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fetch_en,
    output logic store_en
);
    rmw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_FETCH : ST_IDLE;
            ST_FETCH: state_d = ST_STORE;
            ST_STORE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        fetch_en = 1'b0;
        store_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin
                busy     = 1'b1;
                fetch_en = 1'b1;
            end
            ST_STORE: begin
                busy     = 1'b1;
                store_en = 1'b1;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/pfx_keymap.sv
module pfx_keymap
    import pkm_pkg::*;
#(
    parameter int AW         = 32,
    parameter int KEY_FRAMES = 64,
    localparam int IDX_W     = $clog2(KEY_FRAMES),
    localparam int PB_W      = AW - BLOCK_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             dat_on,
    input  logic [AW-1:0]    xlat_addr,
    input  logic [AW-1:0]    log_addr,
    input  logic             xlat_ok,
    input  logic             perm_rd,
    input  logic             perm_wr,
    input  logic [PB_W-1:0]  prefix_blk,
    input  logic [AW-1:0]    mem_top,
    output logic             busy,
    output logic             resp_valid,
    output logic [AW-1:0]    abs_addr,
    input  logic             kp_en,
    input  logic             kp_we,
    input  logic [IDX_W-1:0] kp_idx,
    input  logic [KEY_W-1:0] kp_wdata,
    output logic [KEY_W-1:0] kp_rdata
);
    localparam int CAP_SHIFT = FRAME_SHIFT + IDX_W;

    logic [AW-1:0]    real_c;
    logic [AW-1:0]    abs_c;
    logic             ok_c;
    logic             in_cap_c;
    logic             upd_c;
    logic             accept;
    logic             fetch_en;
    logic             store_en;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       perm_q;
    key_t             rmw_q;
    key_t             merged;
    key_t             host_q;

    assign real_c = dat_on ? xlat_addr : log_addr;
    assign ok_c   = !dat_on || xlat_ok;
    assign accept = req_valid && !busy;

    pkm_remap #(.AW(AW)) u_remap (
        .real_addr (real_c),
        .pfx_blk   (prefix_blk),
        .abs_addr  (abs_c)
    );

    generate
        if (AW > CAP_SHIFT) begin : g_cap_chk
            assign in_cap_c = (abs_c[AW-1:CAP_SHIFT] == '0);
        end else begin : g_cap_all
            assign in_cap_c = 1'b1;
        end
    endgenerate

    assign upd_c = ok_c && in_cap_c && (abs_c < mem_top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abs_addr   <= '0;
            resp_valid <= 1'b0;
            idx_q      <= '0;
            perm_q     <= '0;
        end else begin
            resp_valid <= accept;
            if (accept) begin
                abs_addr <= abs_c;
                idx_q    <= abs_c[CAP_SHIFT-1:FRAME_SHIFT];
                perm_q   <= {perm_rd, perm_wr};
            end
        end
    end

    pkm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && upd_c),
        .busy     (busy),
        .fetch_en (fetch_en),
        .store_en (store_en)
    );

    always_comb begin
        merged      = rmw_q;
        merged.refd = rmw_q.refd | perm_q[1];
        merged.chgd = rmw_q.chgd | perm_q[0];
    end

    pkm_keyram #(.KEY_FRAMES(KEY_FRAMES), .IDX_W(IDX_W)) u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .rmw_rd     (fetch_en),
        .rmw_wr     (store_en),
        .rmw_idx    (idx_q),
        .rmw_wdata  (merged),
        .rmw_q      (rmw_q),
        .host_en    (kp_en),
        .host_we    (kp_we),
        .host_idx   (kp_idx),
        .host_wdata (key_t'(kp_wdata)),
        .host_q     (host_q)
    );

    assign kp_rdata = host_q;
endmodule

// File: rtl/pkm_checker.sv
module pkm_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          resp_valid,
    input logic          dat_on,
    input logic [AW-1:0] xlat_addr,
    input logic [AW-1:0] log_addr,
    input logic [AW-1:0] abs_addr
);
    assert_resp_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> resp_valid);

    assert_no_resp_when_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !busy) |=> !resp_valid);

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=>
            abs_addr[12:0] == $past(dat_on ? xlat_addr[12:0] : log_addr[12:0]));

    assert_busy_second_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    assert_busy_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

bind pfx_keymap pkm_checker #(.AW(AW)) u_pkm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .resp_valid (resp_valid),
    .dat_on     (dat_on),
    .xlat_addr  (xlat_addr),
    .log_addr   (log_addr),
    .abs_addr   (abs_addr)
);

// File: tb/test_pfx_keymap.sv
`timescale 1ns/100ps
module test_pfx_keymap;
    localparam int          AW      = 32;
    localparam logic [31:0] MEM_TOP = 32'h0003_0000;
    localparam logic [31:0] CAP     = 32'h0004_0000;
    localparam int          NV      = 16;

    typedef struct packed {
        logic        dat;
        logic [31:0] xa;
        logic [31:0] la;
        logic        ok;
        logic        rd;
        logic        wr;
        logic [18:0] blk;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_0123, 32'h0, 1'b1, 1'b1, 1'b0, 19'd8,  32'h0001_0123},
        '{1'b1, 32'h0000_1FFF, 32'h0, 1'b1, 1'b1, 1'b1, 19'd8,  32'h0001_1FFF},
        '{1'b1, 32'h0000_2000, 32'h0, 1'b1, 1'b1, 1'b0, 19'd8,  32'h0000_2000},
        '{1'b1, 32'h0001_0000, 32'h0, 1'b1, 1'b0, 1'b1, 19'd8,  32'h0000_0000},
        '{1'b1, 32'h0001_1FFF, 32'h0, 1'b1, 1'b1, 1'b0, 19'd8,  32'h0000_1FFF},
        '{1'b1, 32'h0001_2000, 32'h0, 1'b1, 1'b1, 1'b1, 19'd8,  32'h0001_2000},
        '{1'b1, 32'h0000_0050, 32'h0, 1'b1, 1'b0, 1'b1, 19'd9,  32'h0001_2050},
        '{1'b1, 32'h0001_2050, 32'h0, 1'b1, 1'b1, 1'b0, 19'd9,  32'h0000_0050},
        '{1'b1, 32'h0000_5000, 32'h0, 1'b0, 1'b1, 1'b1, 19'd8,  32'h0000_5000},
        '{1'b1, 32'h0003_5000, 32'h0, 1'b1, 1'b1, 1'b1, 19'd8,  32'h0003_5000},
        '{1'b0, 32'h0000_7777, 32'h0000_1004, 1'b0, 1'b1, 1'b0, 19'd8, 32'h0001_1004},
        '{1'b1, 32'h0000_1234, 32'h0, 1'b1, 1'b1, 1'b0, 19'd0,  32'h0000_1234},
        '{1'b1, 32'h0002_1000, 32'h0, 1'b1, 1'b0, 1'b1, 19'd16, 32'h0000_1000},
        '{1'b1, 32'h0000_3000, 32'h0, 1'b1, 1'b0, 1'b0, 19'd8,  32'h0000_3000},
        '{1'b1, 32'h0000_0100, 32'h0, 1'b1, 1'b1, 1'b1, 19'd24, 32'h0003_0100},
        '{1'b1, 32'h0000_FFFF, 32'h0, 1'b1, 1'b1, 1'b0, 19'd8,  32'h0000_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        dat_on = 1'b1;
    logic [31:0] xlat_addr = '0;
    logic [31:0] log_addr = '0;
    logic        xlat_ok = 1'b0;
    logic        perm_rd = 1'b0;
    logic        perm_wr = 1'b0;
    logic [18:0] prefix_blk = '0;
    logic [31:0] mem_top = MEM_TOP;
    logic        busy;
    logic        resp_valid;
    logic [31:0] abs_addr;
    logic        kp_en = 1'b0;
    logic        kp_we = 1'b0;
    logic [5:0]  kp_idx = '0;
    logic [6:0]  kp_wdata = '0;
    logic [6:0]  kp_rdata;

    int   total = 0;
    int   bad = 0;
    logic [6:0] km [64];

    always #2.5 clk = ~clk;

    pfx_keymap #(.AW(AW), .KEY_FRAMES(64)) i_pfx_keymap (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dat_on(dat_on),
        .xlat_addr(xlat_addr), .log_addr(log_addr), .xlat_ok(xlat_ok),
        .perm_rd(perm_rd), .perm_wr(perm_wr), .prefix_blk(prefix_blk),
        .mem_top(mem_top), .busy(busy), .resp_valid(resp_valid),
        .abs_addr(abs_addr), .kp_en(kp_en), .kp_we(kp_we), .kp_idx(kp_idx),
        .kp_wdata(kp_wdata), .kp_rdata(kp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic key_write(input int i, input logic [6:0] d);
        @(negedge clk);
        kp_en = 1'b1; kp_we = 1'b1; kp_idx = i[5:0]; kp_wdata = d;
        @(negedge clk);
        kp_en = 1'b0; kp_we = 1'b0;
    endtask

    task automatic key_read(input int i, output logic [6:0] d);
        @(negedge clk);
        kp_en = 1'b1; kp_we = 1'b0; kp_idx = i[5:0];
        @(negedge clk);
        kp_en = 1'b0;
        d = kp_rdata;
    endtask

    task automatic issue(input vec_t t);
        @(negedge clk);
        req_valid = 1'b1; dat_on = t.dat; xlat_addr = t.xa; log_addr = t.la;
        xlat_ok = t.ok; perm_rd = t.rd; perm_wr = t.wr; prefix_blk = t.blk;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] rk;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", {31'b0, busy}, 32'h0);
        chk("R11 resp_valid", {31'b0, resp_valid}, 32'h0);
        chk("R11 abs_addr", abs_addr, 32'h0);
        rst_n = 1'b1;
        key_read(37, rk);
        chk("R11 key cleared", {25'b0, rk}, 32'h0);

        // R10 preload: acc = i[3:0], fetch-protect = i[0], ref/chg clear
        for (int i = 0; i < 64; i++) begin
            km[i] = {i[3:0], i[0], 2'b00};
            key_write(i, km[i]);
        end
        key_read(5, rk);
        chk("R10 host readback", {25'b0, rk}, {25'b0, km[5]});
        key_read(14, rk);
        chk("R10 host readback", {25'b0, rk}, {25'b0, km[14]});

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            logic upd;
            int   idx;
            t   = VECS[v];
            upd = (t.dat ? t.ok : 1'b1) && (t.exp < MEM_TOP) && (t.exp < CAP);
            idx = int'(t.exp[17:12]);
            if (upd) km[idx] = km[idx] | {5'b0, t.rd, t.wr};
            issue(t);
            chk("R6 resp_valid", {31'b0, resp_valid}, 32'h1);
            chk("R1 R2 R3 R4 R5 abs_addr", abs_addr, t.exp);
            chk("R7 busy start", {31'b0, busy}, {31'b0, upd});
            @(negedge clk);
            chk("R6 resp pulse", {31'b0, resp_valid}, 32'h0);
            chk("R9 busy second", {31'b0, busy}, {31'b0, upd});
            @(negedge clk);
            chk("R9 busy end", {31'b0, busy}, 32'h0);
            key_read(idx, rk);
            chk("R7 R8 key entry", {25'b0, rk}, {25'b0, km[idx]});
        end

        // R9 request while busy is ignored
        km[4] = km[4] | 7'b0000011;
        @(negedge clk);
        req_valid = 1'b1; dat_on = 1'b1; xlat_addr = 32'h0000_4000; xlat_ok = 1'b1;
        perm_rd = 1'b1; perm_wr = 1'b1; prefix_blk = 19'd8;
        @(negedge clk);
        chk("R9 first accepted", {31'b0, resp_valid}, 32'h1);
        xlat_addr = 32'h0000_6000;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 no resp while busy", {31'b0, resp_valid}, 32'h0);
        chk("R9 busy held", {31'b0, busy}, 32'h1);
        @(negedge clk);
        chk("R9 busy drops", {31'b0, busy}, 32'h0);
        key_read(6, rk);
        chk("R9 ignored key unchanged", {25'b0, rk}, {25'b0, km[6]});
        key_read(4, rk);
        chk("R8 accepted key merged", {25'b0, rk}, {25'b0, km[4]});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule